// File: doc/BRIEF.md
# Processor Stack and Context Unit

This block owns the stack pointer and the status register of an 8-bit processor whose stack sits in one fixed memory page. The processor issues one of four commands: push a byte, pop a byte, save context (program counter and status) or restore context. The unit then drives a single-port byte memory. The memory array is outside the block and returns read data one clock after the address is presented.

Commands arrive on a valid/ready handshake. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as a command is executing, so a command held during that time waits, and a command pulsed and withdrawn during that time is dropped. Results carry no back-pressure: `done` pulses for one cycle at the end of every command. In that same cycle `pop_valid` marks `pop_data` for a byte pop, and `pc_out` and `status` hold the restored context after a restore. `status_wr` is a plain control input that loads the status register while the unit is idle.

Top module: `stk_ctx_unit`

## Requirements
- R1: After reset the stack pointer reads 0xFD, the status register reads 0x04, `busy` is low and `cmd_ready` is high.
- R2: Every memory access uses address {0x01, stack pointer}, so every access falls inside 0x0100 to 0x01FF.
- R3: A push-byte command (`cmd_op` = 0) writes `cmd_data` at the current stack address and then lowers the stack pointer by one.
- R4: A pop-byte command (`cmd_op` = 1) first raises the stack pointer by one, reads the byte at the new address, and presents it on `pop_data` with `pop_valid` high in the `done` cycle.
- R5: A save-context command (`cmd_op` = 2) writes three bytes at successively lower addresses: PC high byte, then PC low byte, then the status register. The stack pointer ends three lower.
- R6: A restore-context command (`cmd_op` = 3) reads three bytes at successively higher addresses: status, then PC low byte, then PC high byte. The rebuilt PC appears on `pc_out`, and the stack pointer ends three higher.
- R7: On a restore, bit 4 of the restored status is cleared and bit 5 is set, whatever the stack held.
- R8: The stack pointer wraps modulo 256 in both directions without any error indication.
- R9: `busy` is high and `cmd_ready` low while a command executes. `done` is a single-cycle pulse in a cycle where the unit is idle again. A command presented while busy and withdrawn before ready returns has no effect.
- R10: `status_wr` loads `status_wdata` into the status register when the unit is idle and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 2 | 0 push byte, 1 pop byte, 2 save context, 3 restore context |
| cmd_data | input | 8 | Byte to push |
| cmd_pc | input | 16 | Program counter to save |
| status_wr | input | 1 | Load status register (idle only) |
| status_wdata | input | 8 | Value for status load |
| busy | output | 1 | A command is executing |
| done | output | 1 | One-cycle end-of-command pulse |
| pop_valid | output | 1 | `pop_data` valid (byte pop, with done) |
| pop_data | output | 8 | Popped byte |
| pc_out | output | 16 | Restored program counter |
| status | output | 8 | Status register |
| sp | output | 8 | Stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |

## Verification
The bench targets the pointer's order of operations. If the write and the decrement were swapped, pushes would land one slot off and pops would return neighbouring bytes. Context byte order is checked both in memory after a save and through a restore of hand-pushed bytes, so a swapped PC byte order shows up as a wrong `pc_out` or wrong stack contents. A stored status with bit 4 set and bit 5 clear exposes a missing restore mask. A run of pushes through 0x00 to 0xFF, followed by pops back, exposes a pointer that saturates instead of wrapping. A push and a status write pulsed during a save must leave the pointer, the memory and the status exactly as if they were never offered.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_SAVE    = 2'd2,
    OP_RESTORE = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_TAIL
  } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   INIT = 8'hFD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] sp
);
  // Wraps modulo 2**W by plain binary arithmetic.
  always_ff @(posedge clk) begin
    if (rst)      sp <= INIT;
    else if (inc) sp <= sp + 1'b1;
    else if (dec) sp <= sp - 1'b1;
  end

  // R8
  inc_dec_excl_chk: assert property (@(posedge clk) disable iff (rst) !(inc && dec));
  // R1
  sp_reset_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (sp == INIT));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter int                CTX_N  = 3,
  parameter logic [DATA_W-1:0] PAGE   = 8'h01,
  localparam int               CW     = (CTX_N > 1) ? $clog2(CTX_N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  stk_op_e               cmd_op,
  input  logic [DATA_W-1:0]     sp,
  output logic                  cmd_ready,
  output logic                  busy,
  output logic                  accept,
  output logic                  sp_inc,
  output logic                  sp_dec,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic                  mem_we,
  output logic [CW-1:0]         step,
  output logic                  is_ctx,
  output logic                  rd_pend,
  output logic [CW-1:0]         rd_idx,
  output logic                  done,
  output logic                  pop_valid
);
  stk_state_e st;
  logic       is_read;
  logic [CW-1:0] last;

  assign busy      = (st != ST_IDLE);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign last      = is_ctx ? CW'(CTX_N - 1) : '0;
  assign sp_inc    = (st == ST_READ);
  assign sp_dec    = (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = {PAGE, (st == ST_READ) ? DATA_W'(sp + 1'b1) : sp};
  assign pop_valid = done && is_read && !is_ctx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      step    <= '0;
      is_ctx  <= 1'b0;
      is_read <= 1'b0;
      rd_pend <= 1'b0;
      rd_idx  <= '0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_pend <= (st == ST_READ);
      if (st == ST_READ) rd_idx <= step;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          is_ctx  <= (cmd_op == OP_SAVE) || (cmd_op == OP_RESTORE);
          is_read <= (cmd_op == OP_POP)  || (cmd_op == OP_RESTORE);
          step    <= '0;
          st      <= ((cmd_op == OP_POP) || (cmd_op == OP_RESTORE)) ? ST_READ : ST_WRITE;
        end
        ST_WRITE: begin
          if (step == last) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else step <= step + 1'b1;
        end
        ST_READ: begin
          if (step == last) st <= ST_TAIL;
          else              step <= step + 1'b1;
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp == DATA_W'($past(sp) - 1'b1)));
  // R4
  pop_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sp_inc |=> (sp == $past(mem_addr[DATA_W-1:0])));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (rst) done |-> cmd_ready);
endmodule

// File: rtl/stk_ctx_regs.sv
module stk_ctx_regs #(
  parameter int                DATA_W  = 8,
  parameter int                PC_W    = 16,
  parameter int                CTX_N   = 3,
  parameter logic [DATA_W-1:0] ST_INIT = 8'h04,
  parameter int                CLR_BIT = 4,
  parameter int                SET_BIT = 5,
  localparam int               PCB     = PC_W / DATA_W,
  localparam int               CW      = (CTX_N > 1) ? $clog2(CTX_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic              status_wr,
  input  logic [DATA_W-1:0] status_wdata,
  input  logic              busy,
  input  logic              is_ctx,
  input  logic [CW-1:0]     step,
  input  logic              rd_pend,
  input  logic [CW-1:0]     rd_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] status,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] pop_data
);
  localparam logic [DATA_W-1:0] CLR_M = DATA_W'(1) << CLR_BIT;
  localparam logic [DATA_W-1:0] SET_M = DATA_W'(1) << SET_BIT;

  logic [DATA_W-1:0] data_q;
  logic [PC_W-1:0]   pc_q;

  // Save order: PC bytes from most significant down, status last.
  always_comb begin
    mem_wdata = data_q;
    if (is_ctx) begin
      mem_wdata = status;
      for (int k = 0; k < PCB; k++)
        if (int'(step) == k) mem_wdata = pc_q[(PCB-1-k)*DATA_W +: DATA_W];
    end
  end

  // Restore order: status first, then PC bytes from least significant up.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      pc_q     <= '0;
      status   <= ST_INIT;
      pc_out   <= '0;
      pop_data <= '0;
    end else begin
      if (accept) begin
        data_q <= cmd_data;
        pc_q   <= cmd_pc;
      end
      if (!busy && status_wr) status <= status_wdata;
      if (rd_pend) begin
        if (!is_ctx) pop_data <= mem_rdata;
        else if (rd_idx == '0) status <= (mem_rdata & ~CLR_M) | SET_M;
        else begin
          for (int k = 1; k <= PCB; k++)
            if (int'(rd_idx) == k) pc_out[(k-1)*DATA_W +: DATA_W] <= mem_rdata;
        end
      end
    end
  end

  // R7
  restore_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && is_ctx && rd_idx == '0) |=> (!status[CLR_BIT] && status[SET_BIT]));
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_pend) |=> $stable(status));
endmodule

// File: rtl/stk_ctx_unit.sv
module stk_ctx_unit
  import stk_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter int                PC_W    = 16,
  parameter logic [DATA_W-1:0] PAGE    = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFD,
  parameter logic [DATA_W-1:0] ST_INIT = 8'h04,
  parameter int                CLR_BIT = 4,
  parameter int                SET_BIT = 5,
  localparam int               CTX_N   = PC_W / DATA_W + 1,
  localparam int               CW      = (CTX_N > 1) ? $clog2(CTX_N) : 1,
  localparam int               ADDR_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic              status_wr,
  input  logic [DATA_W-1:0] status_wdata,
  output logic              busy,
  output logic              done,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic [PC_W-1:0]   pc_out,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic          accept, sp_inc, sp_dec, is_ctx, rd_pend;
  logic [CW-1:0] step, rd_idx;

  stk_ptr #(.W(DATA_W), .INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst(rst), .inc(sp_inc), .dec(sp_dec), .sp(sp)
  );

  stk_seq #(.DATA_W(DATA_W), .CTX_N(CTX_N), .PAGE(PAGE)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(stk_op_e'(cmd_op)),
    .sp(sp), .cmd_ready(cmd_ready), .busy(busy), .accept(accept),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .mem_addr(mem_addr), .mem_we(mem_we),
    .step(step), .is_ctx(is_ctx), .rd_pend(rd_pend), .rd_idx(rd_idx),
    .done(done), .pop_valid(pop_valid)
  );

  stk_ctx_regs #(
    .DATA_W(DATA_W), .PC_W(PC_W), .CTX_N(CTX_N), .ST_INIT(ST_INIT),
    .CLR_BIT(CLR_BIT), .SET_BIT(SET_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .cmd_data(cmd_data), .cmd_pc(cmd_pc),
    .status_wr(status_wr), .status_wdata(status_wdata), .busy(busy),
    .is_ctx(is_ctx), .step(step), .rd_pend(rd_pend), .rd_idx(rd_idx),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .status(status),
    .pc_out(pc_out), .pop_data(pop_data)
  );
endmodule

// File: tb/stk_ctx_unit_test.sv
module stk_ctx_unit_test;
  import stk_pkg::*;

  typedef struct {
    bit         has_pop;
    logic [7:0] pop_v;
    bit         has_ctx;
    logic [15:0] pc;
    logic [7:0] st;
    logic [7:0] spv;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic [15:0] cmd_pc = 16'h0000;
  logic status_wr = 1'b0;
  logic [7:0] status_wdata = 8'h00;
  logic busy, done, pop_valid;
  logic [7:0] pop_data, status, sp, mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [15:0] pc_out, mem_addr;
  logic mem_we;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [7:0] tb_mem [0:255];
  logic [7:0] m_mem  [0:255];
  logic [7:0] m_sp = 8'hFD, m_st = 8'h04;

  always #5 clk = ~clk;

  stk_ctx_unit uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_pc(cmd_pc),
    .status_wr(status_wr), .status_wdata(status_wdata), .busy(busy),
    .done(done), .pop_valid(pop_valid), .pop_data(pop_data), .pc_out(pc_out),
    .status(status), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory with one-cycle read latency.
  always @(posedge clk) begin
    if (mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= tb_mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  // Monitor: compares every completed command with the scoreboard.
  always @(negedge clk) begin
    if (!rst && (mem_we || busy)) begin
      if (mem_addr[15:8] !== 8'h01) chk("R2 page", mem_addr, {8'h01, mem_addr[7:0]});
    end
    if (!rst && done) begin
      chk("R9 ready at done", {15'd0, cmd_ready}, 16'd1);
      if (exp_q.size() == 0) chk("R9 unexpected done", 16'd1, 16'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " sp"}, {8'h00, sp}, {8'h00, e.spv});
        chk({e.tag, " status"}, {8'h00, status}, {8'h00, e.st});
        chk({e.tag, " pop_valid"}, {15'd0, pop_valid}, {15'd0, e.has_pop});
        if (e.has_pop) chk({e.tag, " pop_data"}, {8'h00, pop_data}, {8'h00, e.pop_v});
        if (e.has_ctx) chk({e.tag, " pc"}, pc_out, e.pc);
      end
    end
  end

  // Scoreboard entry from the requirements, then drive the handshake.
  task automatic queue_exp(input logic [1:0] op, input logic [7:0] d,
                           input logic [15:0] pc, input string tag);
    exp_t e;
    logic [7:0] s, lo, hi;
    e.has_pop = 0; e.has_ctx = 0; e.pop_v = 8'h00; e.pc = 16'h0000; e.tag = tag;
    case (op)
      2'd0: begin m_mem[m_sp] = d; m_sp = m_sp - 1; end
      2'd1: begin m_sp = m_sp + 1; e.pop_v = m_mem[m_sp]; e.has_pop = 1; end
      2'd2: begin
        m_mem[m_sp] = pc[15:8]; m_sp = m_sp - 1;
        m_mem[m_sp] = pc[7:0];  m_sp = m_sp - 1;
        m_mem[m_sp] = m_st;     m_sp = m_sp - 1;
      end
      default: begin
        m_sp = m_sp + 1; s  = m_mem[m_sp];
        m_sp = m_sp + 1; lo = m_mem[m_sp];
        m_sp = m_sp + 1; hi = m_mem[m_sp];
        m_st = (s & 8'hEF) | 8'h20;
        e.pc = {hi, lo}; e.has_ctx = 1;
      end
    endcase
    e.spv = m_sp; e.st = m_st;
    exp_q.push_back(e);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d,
                       input logic [15:0] pc, input string tag);
    queue_exp(op, d, pc, tag);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d; cmd_pc = pc;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() == 0 && cmd_ready) break;
    end
  endtask

  task automatic set_status(input logic [7:0] v);
    while (!cmd_ready) @(negedge clk);
    status_wr = 1; status_wdata = v;
    @(negedge clk);
    status_wr = 0;
    m_st = v;
    chk("R10 status load", {8'h00, status}, {8'h00, v});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin tb_mem[i] = 8'h00; m_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 sp reset", {8'h00, sp}, 16'h00FD);
    chk("R1 status reset", {8'h00, status}, 16'h0004);
    chk("R1 busy reset", {15'd0, busy}, 16'd0);
    chk("R1 ready reset", {15'd0, cmd_ready}, 16'd1);

    // R3 / R4: byte pushes land at FD then FC, pops return LIFO.
    issue(2'd0, 8'hA5, 16'h0, "R3 push");
    issue(2'd0, 8'h3C, 16'h0, "R3 push");
    wait_idle();
    chk("R3 mem FD", {8'h00, tb_mem[8'hFD]}, 16'h00A5);
    chk("R3 mem FC", {8'h00, tb_mem[8'hFC]}, 16'h003C);
    issue(2'd1, 8'h00, 16'h0, "R4 pop");
    issue(2'd1, 8'h00, 16'h0, "R4 pop");
    wait_idle();

    // R5: save order in memory.
    set_status(8'hD3);
    issue(2'd2, 8'h00, 16'hBEEF, "R5 save");
    wait_idle();
    chk("R5 pc hi", {8'h00, tb_mem[8'(m_sp + 3)]}, 16'h00BE);
    chk("R5 pc lo", {8'h00, tb_mem[8'(m_sp + 2)]}, 16'h00EF);
    chk("R5 status", {8'h00, tb_mem[8'(m_sp + 1)]}, 16'h00D3);

    // R6 / R7: restore, status 0xD3 comes back as 0xE3.
    set_status(8'h00);
    issue(2'd3, 8'h00, 16'h0, "R6 R7 restore");
    wait_idle();
    chk("R7 restored status", {8'h00, status}, 16'h00E3);

    // R6 / R7: hand-pushed context bytes.
    issue(2'd0, 8'h12, 16'h0, "R6 push hi");
    issue(2'd0, 8'h34, 16'h0, "R6 push lo");
    issue(2'd0, 8'h10, 16'h0, "R6 push st");
    issue(2'd3, 8'h00, 16'h0, "R6 R7 manual restore");
    wait_idle();
    chk("R6 pc manual", pc_out, 16'h1234);
    chk("R7 status manual", {8'h00, status}, 16'h0020);

    // R9 / R10: push and status write offered while busy are dropped.
    set_status(8'h81);
    issue(2'd2, 8'h00, 16'h55AA, "R9 save");
    chk("R9 busy during save", {15'd0, busy}, 16'd1);
    chk("R9 ready low", {15'd0, cmd_ready}, 16'd0);
    cmd_valid = 1; cmd_op = 2'd0; cmd_data = 8'hEE;
    status_wr = 1; status_wdata = 8'hFF;
    @(negedge clk);
    cmd_valid = 0; status_wr = 0;
    wait_idle();
    chk("R10 status kept", {8'h00, status}, 16'h0081);
    issue(2'd3, 8'h00, 16'h0, "R9 restore after ignore");
    wait_idle();

    // R8: wrap down through 0x00 to 0xFF and back up.
    while (m_sp != 8'h00) issue(2'd0, m_sp ^ 8'h5A, 16'h0, "R8 fill");
    issue(2'd0, 8'h77, 16'h0, "R8 push wrap");
    wait_idle();
    chk("R8 sp wrapped down", {8'h00, sp}, 16'h00FF);
    issue(2'd1, 8'h00, 16'h0, "R8 pop wrap");
    wait_idle();
    chk("R8 sp wrapped up", {8'h00, sp}, 16'h0000);
    issue(2'd1, 8'h00, 16'h0, "R8 pop after wrap");
    wait_idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule